// File: doc/BRIEF.md
# Period-List Playback DMA Sequencer

This block is the fetch engine of one playback channel. Audio is not held in a single ring. Memory holds a table of period descriptors, and each 8-byte descriptor names a buffer and the length of that buffer in bytes. The engine reads the descriptor that the list pointer selects. It then streams that period's samples, one 32-bit word at a time, from a memory read port into a downstream sample FIFO. At the end of each period it steps to the next descriptor, goes back to entry 0 after the last one, and sets a sticky interrupt-pending bit.

Software controls the channel through plain configuration inputs: a control word that carries the channel's start bit, the list base address, a list-size word and a period-end word. The period-end word can halt the channel at a chosen byte offset. The list pointer, the in-period byte position and the pending bit are visible as outputs. The memory port allows one read in flight. A read is a single-cycle request, and it is answered some cycles later by a single-cycle valid carrying the data.

Top module: `plist_dma_seq`

## Requirements
- R1: The descriptor at `list_base + list_ptr` is read before any sample of its period is read. Its first word (offset 0) is the buffer address. Bits [31:16] of its second word (offset 4) are the period length in bytes.
- R2: Sample reads go to `buffer address + period_pos` and step by 4 bytes. Each returned word is pushed to the FIFO once, unchanged, and in request order.
- R3: When the in-period byte position reaches the period length, `period_pos` returns to 0 and `list_ptr` advances by 8. The next descriptor is then read.
- R4: When a period ends and `list_ptr` equals bits [21:16] of `list_size_word` (the byte offset of the last entry), `list_ptr` wraps to 0.
- R5: `irq_pending` is set only when a period completes, and never part-way through a period.
- R6: `irq_pending` stays set until a cycle with `irq_clr` high clears it. A new period end in that same cycle keeps it set.
- R7: If `end_word` bit 16 is 1 and the in-period byte position reaches `end_word[15:0]`, the channel halts and issues no further reads while its start bit stays high. If bit 16 is 0, that position has no effect.
- R8: The channel runs while `ctrl_word[CH_ID]` is 1. When the bit is cleared, no new read is issued, a read already in flight completes, and `list_ptr` and `period_pos` hold. Setting the bit again refetches the descriptor and resumes at the held position.
- R9: Capture start bits `ctrl_word[11:8]` and the start bits of other channels do not start this channel.
- R10: No sample read is issued while `fifo_full` is high. Descriptor reads may still go out.
- R11: At most one memory read is outstanding at any time.
- R12: After reset, `list_ptr`, `period_pos` and `irq_pending` are 0 and no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Control word; bit CH_ID starts this channel |
| list_base | input | 32 | Byte address of descriptor entry 0 |
| list_size_word | input | 32 | Byte offset of the last entry, in bits [21:16] |
| end_word | input | 32 | Halt offset [15:0]; halt enable in bit 16 |
| irq_clr | input | 1 | Clears the pending bit when high |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr | output | 1 | Push strobe to the FIFO |
| fifo_data | output | 32 | Sample word pushed |
| list_ptr | output | 6 | Byte offset of the current descriptor |
| period_pos | output | 16 | Byte position inside the current period |
| irq_pending | output | 1 | Sticky period-complete interrupt |

## Verification
The streaming function is driven with lists of two and three entries and with periods of different lengths. Each sample word encodes its own address, so a skipped, repeated or misplaced word shows up in the data compared against the expected stream, and the pointer value read at each interrupt separates a correct wrap from an early or late one. The halt offset is tried with its enable bit set and clear, and the start bit is dropped in the middle of a period and later raised again. Back-pressure is applied before any sample is fetched, and control words with only capture or foreign start bits set are applied. Each of these patterns isolates one gating path, seen through the read-request count, the position output and the pushed words.

// File: rtl/plist_pkg.sv
package plist_pkg;
  localparam int ENTRY_BYTES = 8;
  localparam int LEN_WORD_OFS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DSC_A_REQ,
    ST_DSC_A_WAIT,
    ST_DSC_L_REQ,
    ST_DSC_L_WAIT,
    ST_DAT_REQ,
    ST_DAT_WAIT,
    ST_HALT
  } seq_state_e;
endpackage

// File: rtl/plist_ptr_step.sv
module plist_ptr_step #(
  parameter int PTR_W = 6
) (
  input  logic [PTR_W-1:0] cur_ptr,
  input  logic [PTR_W-1:0] last_ptr,
  output logic [PTR_W-1:0] nxt_ptr
);
  import plist_pkg::*;

  always_comb begin
    if (cur_ptr == last_ptr) nxt_ptr = '0;
    else                     nxt_ptr = cur_ptr + PTR_W'(ENTRY_BYTES);
  end
endmodule

// File: rtl/plist_pos_step.sv
module plist_pos_step #(
  parameter int POS_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] per_len,
  input  logic [POS_W-1:0] end_pos,
  input  logic             end_en,
  output logic [POS_W-1:0] pos_nxt,
  output logic             period_done,
  output logic             halt_hit
);
  logic [POS_W:0] pos_inc;

  always_comb begin
    pos_inc     = {1'b0, pos} + (POS_W+1)'(WORD_BYTES);
    period_done = (pos_inc == {1'b0, per_len});
    halt_hit    = end_en && (pos_inc[POS_W-1:0] == end_pos);
    pos_nxt     = period_done ? '0 : pos_inc[POS_W-1:0];
  end
endmodule

// File: rtl/plist_irq_flag.sv
module plist_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_d;

  always_comb begin
    pend_d = pend_o;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end
endmodule

// File: rtl/plist_dma_seq.sv
module plist_dma_seq #(
  parameter int CH_ID = 0,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PTR_W = 6,
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      ctrl_word,
  input  logic [AW-1:0]    list_base,
  input  logic [31:0]      list_size_word,
  input  logic [31:0]      end_word,
  input  logic             irq_clr,
  output logic             mem_rd_req,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [DW-1:0]    mem_rd_data,
  input  logic             fifo_full,
  output logic             fifo_wr,
  output logic [DW-1:0]    fifo_data,
  output logic [PTR_W-1:0] list_ptr,
  output logic [POS_W-1:0] period_pos,
  output logic             irq_pending
);
  import plist_pkg::*;

  localparam int WORD_BYTES = DW / 8;
  localparam int LSZ_LSB    = 16;

  seq_state_e       st, st_d;
  logic [AW-1:0]    buf_addr;
  logic [POS_W-1:0] per_len;
  logic             ld_buf, ld_len, adv;
  logic             run;
  logic             dat_phase;
  logic [PTR_W-1:0] ptr_nxt;
  logic [POS_W-1:0] pos_nxt;
  logic             period_done, halt_hit;
  logic             unused_bits;

  assign run         = ctrl_word[CH_ID];
  assign dat_phase   = (st == ST_DAT_REQ);
  assign unused_bits = ^{ctrl_word, list_size_word, end_word, mem_rd_data};

  plist_ptr_step #(.PTR_W(PTR_W)) u_ptr (
    .cur_ptr  (list_ptr),
    .last_ptr (list_size_word[LSZ_LSB +: PTR_W]),
    .nxt_ptr  (ptr_nxt)
  );

  plist_pos_step #(.POS_W(POS_W), .WORD_BYTES(WORD_BYTES)) u_pos (
    .pos         (period_pos),
    .per_len     (per_len),
    .end_pos     (end_word[POS_W-1:0]),
    .end_en      (end_word[POS_W]),
    .pos_nxt     (pos_nxt),
    .period_done (period_done),
    .halt_hit    (halt_hit)
  );

  plist_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (adv && period_done),
    .clr_i  (irq_clr),
    .pend_o (irq_pending)
  );

  // next-state and read-port decode
  always_comb begin
    st_d        = st;
    mem_rd_req  = 1'b0;
    mem_rd_addr = '0;
    ld_buf      = 1'b0;
    ld_len      = 1'b0;
    adv         = 1'b0;
    unique case (st)
      ST_IDLE: if (run) st_d = ST_DSC_A_REQ;
      ST_DSC_A_REQ: begin
        if (!run) st_d = ST_IDLE;
        else begin
          mem_rd_req  = 1'b1;
          mem_rd_addr = list_base + AW'(list_ptr);
          st_d        = ST_DSC_A_WAIT;
        end
      end
      ST_DSC_A_WAIT: if (mem_rd_valid) begin
        ld_buf = 1'b1;
        st_d   = ST_DSC_L_REQ;
      end
      ST_DSC_L_REQ: begin
        if (!run) st_d = ST_IDLE;
        else begin
          mem_rd_req  = 1'b1;
          mem_rd_addr = list_base + AW'(list_ptr) + AW'(LEN_WORD_OFS);
          st_d        = ST_DSC_L_WAIT;
        end
      end
      ST_DSC_L_WAIT: if (mem_rd_valid) begin
        ld_len = 1'b1;
        st_d   = ST_DAT_REQ;
      end
      ST_DAT_REQ: begin
        if (!run) st_d = ST_IDLE;
        else if (!fifo_full) begin
          mem_rd_req  = 1'b1;
          mem_rd_addr = buf_addr + AW'(period_pos);
          st_d        = ST_DAT_WAIT;
        end
      end
      ST_DAT_WAIT: if (mem_rd_valid) begin
        adv = 1'b1;
        if (halt_hit)         st_d = ST_HALT;
        else if (period_done) st_d = ST_DSC_A_REQ;
        else                  st_d = ST_DAT_REQ;
      end
      ST_HALT: if (!run) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign fifo_wr   = (st == ST_DAT_WAIT) && mem_rd_valid;
  assign fifo_data = mem_rd_data;

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      buf_addr   <= '0;
      per_len    <= '0;
      list_ptr   <= '0;
      period_pos <= '0;
    end else begin
      st <= st_d;
      if (ld_buf) buf_addr <= mem_rd_data[AW-1:0];
      if (ld_len) per_len  <= mem_rd_data[DW-1 -: POS_W];
      if (adv) period_pos  <= pos_nxt;
      if (adv && period_done) list_ptr <= ptr_nxt;
    end
  end
endmodule

// File: rtl/plist_dma_seq_chk.sv
module plist_dma_seq_chk #(
  parameter int CH_ID = 0,
  parameter int PTR_W = 6,
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      ctrl_word,
  input logic [31:0]      list_size_word,
  input logic             irq_clr,
  input logic             mem_rd_req,
  input logic             mem_rd_valid,
  input logic             fifo_full,
  input logic             dat_phase,
  input logic [PTR_W-1:0] list_ptr,
  input logic [POS_W-1:0] period_pos,
  input logic             irq_pending
);
  logic [1:0] outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else if (mem_rd_req && !mem_rd_valid) outst <= outst + 2'd1;
    else if (!mem_rd_req && mem_rd_valid && outst != 2'd0) outst <= outst - 2'd1;
  end

  a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (outst == 2'd0));

  a_r10_no_sample_read_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_phase && mem_rd_req) |-> !fifo_full);

  a_r6_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_clr) |=> irq_pending);

  a_r5_irq_at_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> (period_pos == '0));

  a_r8_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[CH_ID] && !mem_rd_valid) |=> ($stable(period_pos) && $stable(list_ptr)));

  a_r4_ptr_within_list: assert property (@(posedge clk) disable iff (!rst_n)
    list_ptr <= list_size_word[16 +: PTR_W]);
endmodule

bind plist_dma_seq plist_dma_seq_chk #(.CH_ID(CH_ID), .PTR_W(PTR_W), .POS_W(POS_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ctrl_word      (ctrl_word),
  .list_size_word (list_size_word),
  .irq_clr        (irq_clr),
  .mem_rd_req     (mem_rd_req),
  .mem_rd_valid   (mem_rd_valid),
  .fifo_full      (fifo_full),
  .dat_phase      (dat_phase),
  .list_ptr       (list_ptr),
  .period_pos     (period_pos),
  .irq_pending    (irq_pending)
);

// File: tb/sim_plist_dma_seq.sv
`timescale 1ns/1ps
module sim_plist_dma_seq;
  localparam int    CYC = 20;
  localparam logic [31:0] LB = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] list_base = LB;
  logic [31:0] list_size_word = '0;
  logic [31:0] end_word = '0;
  logic        irq_clr = 1'b0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        fifo_full = 1'b0;
  logic        fifo_wr;
  logic [31:0] fifo_data;
  logic [5:0]  list_ptr;
  logic [15:0] period_pos;
  logic        irq_pending;

  logic [15:0] plen [8];
  logic [31:0] got [1024];
  int gcnt = 0;
  int reqcnt = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  plist_dma_seq u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .list_base(list_base),
    .list_size_word(list_size_word), .end_word(end_word), .irq_clr(irq_clr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .list_ptr(list_ptr), .period_pos(period_pos),
    .irq_pending(irq_pending)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    int e;
    if (a >= LB && a < LB + 32'd64) begin
      e = int'((a - LB) >> 3);
      if (a[2] == 1'b0) return 32'h0001_0000 + 32'(e) * 32'h1000;
      else              return {plen[e], 16'h0000};
    end
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] exp_word(input int entry, input int ofs);
    return (32'h0001_0000 + 32'(entry) * 32'h1000 + 32'(ofs)) ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_req) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= mem_word(mem_rd_addr);
      reqcnt       <= reqcnt + 1;
    end
    if (fifo_wr) begin
      got[gcnt % 1024] <= fifo_data;
      gcnt <= gcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ctrl_word = '0; irq_clr = 1'b0; fifo_full = 1'b0; end_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_irq(input string tag);
    int n = 0;
    while (!irq_pending && n < 2000) begin @(negedge clk); n++; end
    if (!irq_pending) chk(1'b0, {tag, " irq timeout"}, 32'd0, 32'd1);
  endtask

  task automatic wait_words(input int base, input int n);
    int k = 0;
    while (gcnt - base < n && k < 2000) begin @(negedge clk); k++; end
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic chk_stream(input int base, input int n, input int entry, input int ofs, input string tag);
    bit ok = 1'b1;
    logic [31:0] a = '0, e = '0;
    for (int i = 0; i < n; i++) begin
      if (ok && got[(base + i) % 1024] !== exp_word(entry, ofs + 4*i)) begin
        ok = 1'b0; a = got[(base + i) % 1024]; e = exp_word(entry, ofs + 4*i);
      end
    end
    chk(ok, tag, a, e);
  endtask

  task automatic t_reset();
    do_reset();
    chk(list_ptr == 6'd0, "R12 list_ptr after reset", 32'(list_ptr), 32'd0);
    chk(period_pos == 16'd0, "R12 period_pos after reset", 32'(period_pos), 32'd0);
    chk(irq_pending == 1'b0, "R12 irq after reset", 32'(irq_pending), 32'd0);
    chk(mem_rd_req == 1'b0, "R12 no request after reset", 32'(mem_rd_req), 32'd0);
  endtask

  task automatic t_basic();
    int base;
    do_reset();
    plen[0] = 16'd64; plen[1] = 16'd128;
    list_size_word = 32'h0008_0000;
    base = gcnt;
    ctrl_word = 32'h1;
    wait_words(base, 8);
    chk(irq_pending == 1'b0, "R5 no irq mid-period", 32'(irq_pending), 32'd0);
    wait_irq("R5");
    chk(gcnt - base == 16, "R5 irq after full period", 32'(gcnt - base), 32'd16);
    chk(list_ptr == 6'd8, "R3 ptr advances by 8", 32'(list_ptr), 32'd8);
    chk(period_pos == 16'd0, "R3 pos returns to 0", 32'(period_pos), 32'd0);
    chk_stream(base, 16, 0, 0, "R1 R2 period 0 data");
    repeat (4) @(negedge clk);
    chk(irq_pending == 1'b1, "R6 pending stays set", 32'(irq_pending), 32'd1);
    pulse_clr();
    chk(irq_pending == 1'b0, "R6 clear by write", 32'(irq_pending), 32'd0);
    wait_irq("R4");
    chk(list_ptr == 6'd0, "R4 wrap after two entries", 32'(list_ptr), 32'd0);
    chk(gcnt - base == 48, "R3 second period length", 32'(gcnt - base), 32'd48);
    chk_stream(base + 16, 32, 1, 0, "R1 R2 period 1 data");
    ctrl_word = '0;
  endtask

  task automatic t_wrap3();
    int base;
    logic [5:0] exp_ptr [4];
    exp_ptr[0] = 6'd8; exp_ptr[1] = 6'd16; exp_ptr[2] = 6'd0; exp_ptr[3] = 6'd8;
    do_reset();
    for (int i = 0; i < 8; i++) plen[i] = 16'd64;
    list_size_word = 32'h0010_0000;
    base = gcnt;
    ctrl_word = 32'h1;
    for (int p = 0; p < 4; p++) begin
      wait_irq("R4");
      chk(list_ptr == exp_ptr[p], "R4 pointer sequence with 3 entries", 32'(list_ptr), 32'(exp_ptr[p]));
      pulse_clr();
    end
    chk_stream(base + 32, 16, 2, 0, "R2 third entry data");
    chk_stream(base + 48, 1, 0, 0, "R4 data after wrap from entry 0");
    ctrl_word = '0;
  endtask

  task automatic t_halt();
    int base, r0;
    do_reset();
    plen[0] = 16'd64; plen[1] = 16'd64;
    list_size_word = 32'h0008_0000;
    end_word = 32'h0001_0020;
    base = gcnt;
    ctrl_word = 32'h1;
    repeat (60) @(negedge clk);
    r0 = reqcnt;
    repeat (50) @(negedge clk);
    chk(gcnt - base == 8, "R7 halt after 8 words", 32'(gcnt - base), 32'd8);
    chk(period_pos == 16'd32, "R7 pos held at end offset", 32'(period_pos), 32'd32);
    chk(reqcnt == r0, "R7 no reads while halted", 32'(reqcnt), 32'(r0));
    chk(irq_pending == 1'b0, "R7 R5 no irq on halt", 32'(irq_pending), 32'd0);
    do_reset();
    end_word = 32'h0000_0020;
    base = gcnt;
    ctrl_word = 32'h1;
    wait_irq("R7");
    chk(gcnt - base == 16, "R7 flag clear ignores end offset", 32'(gcnt - base), 32'd16);
    ctrl_word = '0;
  endtask

  task automatic t_startclr();
    int base, n1, r0;
    logic [15:0] p1;
    do_reset();
    plen[0] = 16'd64; plen[1] = 16'd64;
    list_size_word = 32'h0008_0000;
    base = gcnt;
    ctrl_word = 32'h1;
    wait_words(base, 5);
    ctrl_word = '0;
    repeat (10) @(negedge clk);
    n1 = gcnt - base; p1 = period_pos; r0 = reqcnt;
    chk(32'(p1) == 32'(n1 * 4), "R8 pos matches words pushed", 32'(p1), 32'(n1 * 4));
    repeat (30) @(negedge clk);
    chk(gcnt - base == n1, "R8 no pushes while stopped", 32'(gcnt - base), 32'(n1));
    chk(period_pos == p1, "R8 pos held while stopped", 32'(period_pos), 32'(p1));
    chk(reqcnt == r0, "R8 no reads while stopped", 32'(reqcnt), 32'(r0));
    ctrl_word = 32'h1;
    wait_irq("R8");
    chk(gcnt - base == 16, "R8 resume completes period", 32'(gcnt - base), 32'd16);
    chk_stream(base, 16, 0, 0, "R8 resumed stream continuous");
    ctrl_word = '0;
  endtask

  task automatic t_capture();
    int r0;
    do_reset();
    list_size_word = 32'h0008_0000;
    r0 = reqcnt;
    ctrl_word = 32'h0000_0F0E;
    repeat (40) @(negedge clk);
    chk(reqcnt == r0, "R9 capture and foreign start bits ignored", 32'(reqcnt), 32'(r0));
    chk(period_pos == 16'd0, "R9 pos unchanged", 32'(period_pos), 32'd0);
    ctrl_word = '0;
  endtask

  task automatic t_full();
    int base, r0;
    do_reset();
    plen[0] = 16'd64; plen[1] = 16'd64;
    list_size_word = 32'h0008_0000;
    fifo_full = 1'b1;
    base = gcnt; r0 = reqcnt;
    ctrl_word = 32'h1;
    repeat (40) @(negedge clk);
    chk(reqcnt - r0 == 2, "R10 R1 only descriptor reads while full", 32'(reqcnt - r0), 32'd2);
    chk(gcnt - base == 0, "R10 no pushes while full", 32'(gcnt - base), 32'd0);
    fifo_full = 1'b0;
    wait_irq("R10");
    chk(gcnt - base == 16, "R10 period completes after release", 32'(gcnt - base), 32'd16);
    ctrl_word = '0;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) plen[i] = 16'd64;
    t_reset();
    t_basic();
    t_wrap3();
    t_halt();
    t_startclr();
    t_capture();
    t_full();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule